// File: doc/BRIEF.md
# Match-Clear Timer with Edge Capture

This block is one 16-bit up-counting timer channel with a companion capture channel. The counter advances by one on every count strobe while the run control is high. A compare value sets the period: when the counter has reached it, the next strobe returns the counter to zero and raises a compare pulse. Two compare values are special. Zero parks the counter and keeps the compare interrupt raised. All-ones turns the channel into a free-running counter whose wrap raises an overflow pulse instead.

The capture channel watches an asynchronous input. It resynchronises the input to the clock and then samples it on count strobes. On a qualifying transition it copies the counter into a capture register and pulses a capture interrupt. With the capture it stores a flag that says whether at least one match-and-clear occurred since the previous capture. The flag does not say how many. Software that needs the exact number must count compare interrupts itself.

The capture result is a status output, not a stream. The capture pulse qualifies the capture register for one clock. There is no back-pressure: the register keeps its value until the next capture overwrites it, so software must read it before then.

Top module: `match_clear_timer`

## Requirements
- R1: While reset is asserted and directly after it, the counter is 0 and every output is 0.
- R2: On a clock with strobe and run both high the counter advances by one. With run low the counter keeps its value, strobes or not, and resumes from it when run returns high.
- R3: If the compare value is neither 0 nor FFFFH and the counter equals it on a strobe with run high, the counter becomes 0 at that edge and the compare interrupt is high for exactly the following clock.
- R4: If the compare value is 0 the counter is forced to 0 and does not advance. The compare interrupt is high in every clock that follows a clock where run was high with compare value 0.
- R5: On a strobe with run high, a counter at FFFFH wraps to 0 and the overflow interrupt pulses for one clock, unless the compare value is 0. With compare value FFFFH no compare interrupt is ever raised.
- R6: Edge select is a 2-bit code: 00 disables capture, 01 captures rising transitions, 10 falling, 11 both. Transitions of a non-selected kind leave the capture register, the flag and the pending clear record untouched.
- R7: The input passes a 2-flop synchroniser. A transition driven between clock edges e-1 and e is taken at the third strobe that falls on edge e+2 or later. The capture interrupt is high for exactly the clock after that strobe.
- R8: At a capture the register takes the counter value held before that strobe's own update (the pre-clear value on a match). It changes at no other time.
- R9: The flag stored at a capture is 1 if one or more match-and-clear events happened since the previous capture, including one on the capturing strobe, and 0 otherwise. Each capture restarts the record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_stb | input | 1 | Count-enable strobe, one clock wide per count |
| run | input | 1 | Counting enabled when high |
| cmp_val | input | 16 | Compare (period) value |
| edge_sel | input | 2 | Capture edge code (00 off, 01 rise, 10 fall, 11 both) |
| cap_in | input | 1 | Asynchronous capture input |
| cap_val | output | 16 | Captured counter value |
| cap_flag | output | 1 | A match-and-clear occurred since the previous capture |
| cmp_irq | output | 1 | Compare interrupt |
| ovf_irq | output | 1 | Overflow interrupt |
| cap_irq | output | 1 | Capture interrupt pulse |

## Verification
The capture input is toggled at spacings that drift against the compare period. Captures therefore land at every counter phase, including on the matching strobe itself, and this separates a pre-clear sample with flag set from a post-clear one. The same toggling is repeated with strobes every clock and every third clock, and with run held low. This tells apart latency counted in strobes from latency counted in clocks, and shows whether a stopped counter is frozen or drifts. Each edge code is run over an alternating input to show that only the chosen direction is taken. Compare values 0 and FFFFH, and a compare value lowered below the counter, exercise the stuck interrupt, the free-run wrap and the overflow path.

// File: rtl/mct_pkg.sv
package mct_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  function automatic logic edge_taken(input logic [1:0] sel, input logic now_lvl);
    case (edge_sel_e'(sel))
      EDGE_RISE: edge_taken = now_lvl;
      EDGE_FALL: edge_taken = !now_lvl;
      EDGE_BOTH: edge_taken = 1'b1;
      default:   edge_taken = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mct_count_core.sv
module mct_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_stb,
  input  logic             run,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match_evt,
  output logic             cmp_irq,
  output logic             ovf_irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic tick;
  logic cmp_zero;
  logic cmp_full;
  logic wrap_evt;

  always_comb begin
    tick      = cnt_stb && run;
    cmp_zero  = (cmp_val == '0);
    cmp_full  = (cmp_val == CNT_MAX);
    match_evt = tick && !cmp_zero && !cmp_full && (cnt_q == cmp_val);
    wrap_evt  = tick && !cmp_zero && (cnt_q == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmp_irq <= 1'b0;
      ovf_irq <= 1'b0;
    end else begin
      cmp_irq <= (run && cmp_zero) || match_evt;
      ovf_irq <= wrap_evt;
      if (tick) begin
        if (cmp_zero || match_evt) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mct_capture_unit.sv
module mct_capture_unit
  import mct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int EDGE_PIPE   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_stb,
  input  logic             cap_in,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             match_evt,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             cap_irq
);
  localparam int NEW_IDX = EDGE_PIPE - 2;
  localparam int OLD_IDX = EDGE_PIPE - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [EDGE_PIPE-1:0]   pipe_q;
  logic                   clr_seen;
  logic                   fire;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= (g == 0) ? cap_in : sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_comb begin
    fire = cnt_stb && (pipe_q[NEW_IDX] != pipe_q[OLD_IDX]) &&
           edge_taken(edge_sel, pipe_q[NEW_IDX]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q   <= '0;
      clr_seen <= 1'b0;
      cap_val  <= '0;
      cap_flag <= 1'b0;
      cap_irq  <= 1'b0;
    end else begin
      cap_irq <= fire;
      if (cnt_stb) pipe_q <= {pipe_q[EDGE_PIPE-2:0], sync_q[SYNC_STAGES-1]};
      if (fire) begin
        cap_val  <= cnt_q;
        cap_flag <= clr_seen || match_evt;
        clr_seen <= 1'b0;
      end else if (match_evt) begin
        clr_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/match_clear_timer.sv
module match_clear_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_stb,
  input  logic             run,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [1:0]       edge_sel,
  input  logic             cap_in,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             cmp_irq,
  output logic             ovf_irq,
  output logic             cap_irq
);
  logic [CNT_W-1:0] cnt_q;
  logic             match_evt;

  mct_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_stb   (cnt_stb),
    .run       (run),
    .cmp_val   (cmp_val),
    .cnt_q     (cnt_q),
    .match_evt (match_evt),
    .cmp_irq   (cmp_irq),
    .ovf_irq   (ovf_irq)
  );

  mct_capture_unit #(.CNT_W(CNT_W), .SYNC_STAGES(2), .EDGE_PIPE(3)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_stb   (cnt_stb),
    .cap_in    (cap_in),
    .edge_sel  (edge_sel),
    .cnt_q     (cnt_q),
    .match_evt (match_evt),
    .cap_val   (cap_val),
    .cap_flag  (cap_flag),
    .cap_irq   (cap_irq)
  );
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_stb,
  input logic             run,
  input logic [CNT_W-1:0] cmp_val,
  input logic [1:0]       edge_sel,
  input logic [CNT_W-1:0] cap_val,
  input logic             cmp_irq,
  input logic             ovf_irq,
  input logic             cap_irq
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  // R5
  cmp_ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_irq && ovf_irq));

  // R5
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ($past(run) && $past(cnt_stb) && $past(cmp_val) != '0));

  // R5
  no_cmp_in_freerun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> ($past(cmp_val) != ALL_ONES));

  // R4
  stuck_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmp_val == '0) |=> cmp_irq);

  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_irq |-> $stable(cap_val));

  // R6
  cap_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> ($past(edge_sel) != 2'b00 && $past(cnt_stb)));
endmodule

bind match_clear_timer mct_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_stb  (cnt_stb),
  .run      (run),
  .cmp_val  (cmp_val),
  .edge_sel (edge_sel),
  .cap_val  (cap_val),
  .cmp_irq  (cmp_irq),
  .ovf_irq  (ovf_irq),
  .cap_irq  (cap_irq)
);

// File: tb/match_clear_timer_bench.sv
`timescale 1ns/1ps
module match_clear_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_stb = 1'b0;
  logic        run = 1'b0;
  logic [15:0] cmp_val = 16'h0;
  logic [1:0]  edge_sel = 2'b00;
  logic        cap_in = 1'b0;
  logic [15:0] cap_val;
  logic        cap_flag, cmp_irq, ovf_irq, cap_irq;

  always #2.5 clk = ~clk;

  match_clear_timer u_match_clear_timer (
    .clk(clk), .rst_n(rst_n), .cnt_stb(cnt_stb), .run(run), .cmp_val(cmp_val),
    .edge_sel(edge_sel), .cap_in(cap_in), .cap_val(cap_val), .cap_flag(cap_flag),
    .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .cap_irq(cap_irq)
  );

  int    vectors = 0;
  int    miscompares = 0;
  int    stb_period = 1;
  bit    finished = 0;
  string cur_req = "R1";

  // reference model state
  int cyc = 0;
  int m_cnt = 0;
  bit m_clr = 0;
  int e_cap_val = 0;
  bit e_flag = 0, e_cmp = 0, e_ovf = 0, e_cap = 0;
  bit last_in = 0, pend = 0, pdir = 0;
  int pstart = 0, pcnt = 0;

  // strobe generator
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      if (phase >= stb_period - 1) phase = 0; else phase = phase + 1;
      cnt_stb = (phase == 0);
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_cnt = 0; m_clr = 0; e_cap_val = 0; e_flag = 0; e_cmp = 0; e_ovf = 0;
      e_cap = 0; last_in = 0; pend = 0; pcnt = 0;
    end else begin
      bit tick, matched, fire;
      tick    = cnt_stb && run;
      matched = tick && cmp_val != 0 && cmp_val != 16'hFFFF && m_cnt == int'(cmp_val);
      e_cmp   = (run && cmp_val == 0) || matched;
      e_ovf   = tick && cmp_val != 0 && m_cnt == 65535;
      if (cap_in != last_in) begin
        pend = 1; pdir = cap_in; pstart = cyc + 2; pcnt = 0; last_in = cap_in;
      end
      fire = 0;
      if (pend && cnt_stb && cyc >= pstart) begin
        pcnt = pcnt + 1;
        if (pcnt == 3) begin
          pend = 0;
          fire = (edge_sel == 2'b11) || (edge_sel == 2'b01 && pdir) ||
                 (edge_sel == 2'b10 && !pdir);
        end
      end
      e_cap = fire;
      if (fire) begin
        e_cap_val = m_cnt; e_flag = m_clr || matched; m_clr = 0;
      end else if (matched) m_clr = 1;
      if (tick) begin
        if (cmp_val == 0 || matched) m_cnt = 0;
        else m_cnt = (m_cnt + 1) % 65536;
      end
    end
  end

  task automatic chk(input string what, input string req, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s (%s, phase %s) at cycle %0d: actual %0h expected %0h",
               req, what, cur_req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      chk("cap_val",  "R8", int'(cap_val), e_cap_val);
      chk("cap_irq",  "R7", int'(cap_irq), int'(e_cap));
      chk("cap_flag", "R9", int'(cap_flag), int'(e_flag));
      chk("cmp_irq",  "R3", int'(cmp_irq), int'(e_cmp));
      chk("ovf_irq",  "R5", int'(ovf_irq), int'(e_ovf));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggles(input int n);
    for (int i = 0; i < n; i++) begin
      cap_in = ~cap_in;
      wait_cyc(4 * stb_period + 4 + (i % 5));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    $display("FAIL watchdog expired in phase %s", cur_req);
    miscompares++;
    finish_run();
  end

  initial begin
    wait_cyc(4);
    rst_n = 1;
    cur_req = "R1";
    wait_cyc(3);
    // R2 R3 R9: strobe every clock, period of ten counts
    cur_req = "R2";
    cmp_val = 16'd9; edge_sel = 2'b11; run = 1;
    wait_cyc(5);
    toggles(40);
    // R2: stopped counter holds
    run = 0; wait_cyc(20); toggles(6); run = 1;
    // slower strobe, short period
    stb_period = 3; cmp_val = 16'd4;
    toggles(20);
    // R6: edge codes
    cur_req = "R6";
    edge_sel = 2'b01; toggles(10);
    edge_sel = 2'b10; toggles(10);
    edge_sel = 2'b00; toggles(6);
    edge_sel = 2'b11; toggles(4);
    // R4: compare value zero
    cur_req = "R4";
    cmp_val = 16'h0; wait_cyc(30); toggles(4);
    run = 0; wait_cyc(6); run = 1; wait_cyc(6);
    // R5: free run and wrap, then compare lowered below the counter
    cur_req = "R5";
    stb_period = 1; cmp_val = 16'hFFFF;
    wait_cyc(30000); toggles(3);
    wait_cyc(36000); toggles(3);
    cmp_val = 16'd3;
    wait_cyc(66000); toggles(8);
    wait_cyc(10);
    finish_run();
  end
endmodule